// File: doc/BRIEF.md
# Clocked Programmable Digital Delay Line

This block delays one logic signal by a whole number of clock cycles. The delay is a fixed base count plus a 3-bit address code times a per-step count, which gives eight selectable delays. The samples travel along a shift register, and a tap selected by the block's own working copy of the address drives a registered output. An active-low enable forces the output low.

An address change does not take effect as soon as it is requested. The new code waits until no edge is in flight between the old tap and the new tap. When the delay grows, it then also waits a guard time of (new − old) × step cycles. After a disable, the output stays low until the line has been cleared: the enable must be held high and the input held low for the current address × step cycles. Clearing then zeroes every stage, so old history never shows up as a glitch on the output. A one-cycle pulse reports the moment a requested address is applied.

The input is sampled on every rising edge. Because a delay line for a level has no idle samples, there is no valid/ready handshake and no back-pressure: each edge consumes one sample and produces one output value. The address and enable pins are plain level controls. Inputs shorter than about a fifth of the programmed delay are meant to be avoided by the user; the block delays them faithfully and does not filter them.

Top module: `prog_delay_line`

## Requirements
- R1: With working address a, the value of `din` sampled at rising edge n appears on `dout` just after edge n + D, where D = BASE_CYC + a × STEP_CYC. This holds for all eight addresses, and the address is an unsigned binary code.
- R2: The delay rises strictly with the address code: each higher code gives a longer delay than every lower one.
- R3: An edge that samples `en_n` high leaves `dout` low after that edge.
- R4: A value of `addr_req` that differs from the working address is not used for the tap until it is applied. It is applied only while running and enabled. `addr_ready` is a single-cycle pulse, registered at the same edge where the working address updates, and the working address changes at no other time.
- R5: When the line holds no edge, `addr_ready` rises G + 1 edges after the first edge that samples the new code, with G = max(new − old, 0) × STEP_CYC. A move down therefore reports at the edge after the first sample.
- R6: The guard counts only while every line stage between the old tap and the new tap equals `dout`. An edge in that span holds the change back, so a pending edge is neither dropped nor replayed during a change in either direction.
- R7: After a disable, `dout` stays low until the block has seen `en_n` high and `din` low on the current address × STEP_CYC consecutive edges, plus one more edge. Any edge without that condition restarts the count, and re-enabling earlier keeps `dout` low whatever `din` does.
- R8: Completing the clear zeroes the whole line, and the line takes no input while cleared and disabled. After re-enabling, only samples taken after the re-enable can reach `dout`.
- R9: A synchronous active-high reset leaves `dout` low, `addr_ready` low and the working address at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Signal to be delayed, sampled every edge |
| en_n | input | 1 | Output enable, active low |
| addr_req | input | ADDR_W | Requested delay code, held by the user |
| dout | output | 1 | Delayed signal, registered |
| addr_ready | output | 1 | One-cycle pulse when the requested code becomes the working address |

## Verification
The bench builds the block with BASE_CYC = 2, STEP_CYC = 3 and a 3-bit address, which gives a 23-stage line with taps three stages apart. With these values every one of the eight delays, and the longest guard of 21 cycles, fits in a few dozen cycles. A step count above one also makes the guard length a multiple of the address difference that can be told apart from that difference. Short pulses sent just before a change in either direction sit inside the span between the taps, which exercises the hold-back rule. Address 3 gives a clearing interval of nine cycles, short enough to test both an early re-enable and a complete clear.

// File: rtl/pdl_pkg.sv
package pdl_pkg;

  // Enable/clear controller states
  typedef enum logic [1:0] {
    EN_RUN   = 2'd0,  // passing samples to the output
    EN_FLUSH = 2'd1,  // disabled, waiting for the clearing interval
    EN_IDLE  = 2'd2   // line cleared, waiting for re-enable
  } en_state_t;

endpackage

// File: rtl/pdl_tap_line.sv
module pdl_tap_line #(
  parameter int BASE_CYC = 2,
  parameter int STEP_CYC = 3,
  parameter int ADDR_W   = 3,
  parameter int LEN      = BASE_CYC + ((1 << ADDR_W) - 1) * STEP_CYC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  input  logic              feed,       // 1: shift din in, 0: shift zero in
  input  logic              zero_line,  // clear every stage
  input  logic [ADDR_W-1:0] tap_addr,   // working address
  input  logic [ADDR_W-1:0] cmp_addr,   // requested address
  input  logic              ref_lvl,    // level currently on the output
  output logic              tap_bit,
  output logic              span_quiet
);

  localparam int IW = (LEN > 1) ? $clog2(LEN) : 1;

  logic [LEN-1:0] stages;
  logic [LEN-1:0] hit;
  logic [IW-1:0]  tap_idx;
  int             idx_a;
  int             idx_b;
  int             lo_i;
  int             hi_i;

  // Shift register: stage k holds the sample taken k edges ago
  always_ff @(posedge clk) begin
    if (rst || zero_line) begin
      stages <= '0;
    end else begin
      stages <= {stages[LEN-2:0], din & feed};
    end
  end

  // Tap positions for the working and the requested codes
  always_comb begin
    idx_a   = BASE_CYC - 1 + int'(tap_addr) * STEP_CYC;
    idx_b   = BASE_CYC - 1 + int'(cmp_addr) * STEP_CYC;
    lo_i    = (idx_a < idx_b) ? idx_a : idx_b;
    hi_i    = (idx_a < idx_b) ? idx_b : idx_a;
    tap_idx = IW'(idx_a);
  end

  assign tap_bit = stages[tap_idx];

  // A stage inside the span that differs from the output is an edge in flight
  for (genvar i = 0; i < LEN; i++) begin : g_span
    assign hit[i] = (i >= lo_i) && (i <= hi_i) && (stages[i] != ref_lvl);
  end

  assign span_quiet = ~|hit;

endmodule

// File: rtl/pdl_addr_guard.sv
module pdl_addr_guard #(
  parameter int ADDR_W   = 3,
  parameter int STEP_CYC = 3,
  parameter int GW       = $clog2(((1 << ADDR_W) - 1) * STEP_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [ADDR_W-1:0] addr_req,
  input  logic              span_quiet,
  output logic [ADDR_W-1:0] work_addr,
  output logic              addr_ready
);

  logic [ADDR_W-1:0] tgt_q;
  logic [GW-1:0]     gcnt;
  logic [GW-1:0]     gload;
  int                diff;

  // Guard length: upward moves only, scaled by the step count
  always_comb begin
    diff  = int'(addr_req) - int'(work_addr);
    gload = (diff > 0) ? GW'(diff * STEP_CYC) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      work_addr  <= '0;
      tgt_q      <= '0;
      gcnt       <= '0;
      addr_ready <= 1'b0;
    end else begin
      addr_ready <= 1'b0;
      tgt_q      <= addr_req;
      if (!run || (addr_req == work_addr)) begin
        gcnt <= gload;
      end else if ((addr_req != tgt_q) || !span_quiet) begin
        gcnt <= gload;
      end else if (gcnt != '0) begin
        gcnt <= gcnt - 1'b1;
      end else begin
        work_addr  <= addr_req;
        addr_ready <= 1'b1;
      end
    end
  end

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    addr_ready |=> !addr_ready); // R4
  AST_WORK_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (work_addr != $past(work_addr)) |-> addr_ready); // R4
  AST_RUN_ONLY: assert property (@(posedge clk) disable iff (rst)
    addr_ready |-> $past(run)); // R4
  AST_SPAN_QUIET: assert property (@(posedge clk) disable iff (rst)
    addr_ready |-> $past(span_quiet)); // R6

endmodule

// File: rtl/pdl_en_ctrl.sv
module pdl_en_ctrl
  import pdl_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int STEP_CYC = 3,
  parameter int CW       = $clog2(((1 << ADDR_W) - 1) * STEP_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_n,
  input  logic              din,
  input  logic [ADDR_W-1:0] work_addr,
  output logic              pass,
  output logic              feed,
  output logic              zero_line
);

  en_state_t     st;
  logic [CW-1:0] ccnt;
  logic [CW-1:0] clr_len;
  logic          clr_cond;

  assign clr_len   = CW'(int'(work_addr) * STEP_CYC);
  assign clr_cond  = en_n && !din;
  assign zero_line = (st == EN_FLUSH) && clr_cond && (ccnt == '0);
  assign pass      = (st == EN_RUN) && !en_n;
  assign feed      = (st != EN_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= EN_RUN;
      ccnt <= '0;
    end else begin
      case (st)
        EN_RUN: begin
          if (en_n) begin
            st   <= EN_FLUSH;
            ccnt <= clr_len;
          end
        end
        EN_FLUSH: begin
          if (!clr_cond) begin
            ccnt <= clr_len;
          end else if (ccnt != '0) begin
            ccnt <= ccnt - 1'b1;
          end else begin
            st <= EN_IDLE;
          end
        end
        EN_IDLE: begin
          if (!en_n) st <= EN_RUN;
        end
        default: st <= EN_RUN;
      endcase
    end
  end

  AST_IDLE_AFTER_ZERO: assert property (@(posedge clk) disable iff (rst)
    zero_line |=> (st == EN_IDLE)); // R8
  AST_CCNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (st == EN_FLUSH) |-> (ccnt <= clr_len)); // R7

endmodule

// File: rtl/prog_delay_line.sv
module prog_delay_line #(
  parameter int BASE_CYC = 2,
  parameter int STEP_CYC = 3,
  parameter int ADDR_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  input  logic              en_n,
  input  logic [ADDR_W-1:0] addr_req,
  output logic              dout,
  output logic              addr_ready
);

  localparam int NSTEP = 1 << ADDR_W;
  localparam int LEN   = BASE_CYC + (NSTEP - 1) * STEP_CYC;
  localparam int CW    = $clog2((NSTEP - 1) * STEP_CYC + 1);

  logic [ADDR_W-1:0] work_addr;
  logic              pass;
  logic              feed;
  logic              zero_line;
  logic              tap_bit;
  logic              span_quiet;
  logic              dout_q;

  pdl_tap_line #(
    .BASE_CYC(BASE_CYC), .STEP_CYC(STEP_CYC), .ADDR_W(ADDR_W), .LEN(LEN)
  ) u_line (
    .clk(clk), .rst(rst), .din(din), .feed(feed), .zero_line(zero_line),
    .tap_addr(work_addr), .cmp_addr(addr_req), .ref_lvl(dout_q),
    .tap_bit(tap_bit), .span_quiet(span_quiet)
  );

  pdl_addr_guard #(
    .ADDR_W(ADDR_W), .STEP_CYC(STEP_CYC), .GW(CW)
  ) u_guard (
    .clk(clk), .rst(rst), .run(pass), .addr_req(addr_req),
    .span_quiet(span_quiet), .work_addr(work_addr), .addr_ready(addr_ready)
  );

  pdl_en_ctrl #(
    .ADDR_W(ADDR_W), .STEP_CYC(STEP_CYC), .CW(CW)
  ) u_en (
    .clk(clk), .rst(rst), .en_n(en_n), .din(din), .work_addr(work_addr),
    .pass(pass), .feed(feed), .zero_line(zero_line)
  );

  always_ff @(posedge clk) begin
    if (rst) dout_q <= 1'b0;
    else     dout_q <= pass & tap_bit;
  end

  assign dout = dout_q;

  AST_DIS_LOW: assert property (@(posedge clk) disable iff (rst)
    $past(en_n) |-> !dout); // R3

endmodule

// File: tb/test_prog_delay_line.sv
module test_prog_delay_line;

  localparam int CLK_PERIOD = 10;
  localparam int BASE = 2;
  localparam int STEP = 3;
  localparam int AW   = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          din = 1'b0;
  logic          en_n = 1'b0;
  logic [AW-1:0] addr_req = '0;
  logic          dout;
  logic          addr_ready;

  int checks = 0;
  int errors = 0;
  int ecount = 0;
  int cur_addr = 0;
  bit hist [4096];
  logic [7:0] lf = 8'hA5;

  prog_delay_line #(.BASE_CYC(BASE), .STEP_CYC(STEP), .ADDR_W(AW)) i_prog_delay_line (
    .clk(clk), .rst(rst), .din(din), .en_n(en_n), .addr_req(addr_req),
    .dout(dout), .addr_ready(addr_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Record what each rising edge samples
  always @(posedge clk) begin
    hist[ecount % 4096] = din;
    ecount++;
  end

  function automatic int dly(int a);
    return BASE + a * STEP;
  endfunction

  task automatic check(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic lf_next();
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
  endtask

  // Drive a pattern and compare dout with the recorded input D edges back
  task automatic run_pattern(string req, int d, int n);
    int mism = 0;
    for (int c = 0; c < n + d + 2; c++) begin
      din = (c < n) ? lf[0] : 1'b0;
      lf_next();
      @(negedge clk);
      if (dout !== hist[(ecount - 1 - d) % 4096]) mism++;
    end
    check(req, mism, 0);
  endtask

  task automatic set_addr(int a);
    int k = 0;
    bit seen = 0;
    addr_req = AW'(a);
    if (a != cur_addr) begin
      while (!seen && k < 300) begin
        @(negedge clk);
        k++;
        if (addr_ready) seen = 1;
      end
      check("R4 address applied with ready pulse", int'(seen), 1);
      cur_addr = a;
    end
    step(4);
  endtask

  task automatic test_reset();
    check("R9 dout low after reset", int'(dout), 0);
    check("R9 ready low after reset", int'(addr_ready), 0);
  endtask

  task automatic test_all_delays();
    int prev = -1;
    for (int a = 0; a < 8; a++) begin
      int k = 0;
      din = 0;
      step(30);
      set_addr(a);
      step(10);
      din = 1;
      while (!dout && k < 100) begin
        @(negedge clk);
        k++;
      end
      check($sformatf("R1 edge latency addr %0d", a), k - 1, dly(a));
      check($sformatf("R2 monotonic addr %0d", a), int'((k - 1) > prev), 1);
      prev = k - 1;
      din = 0;
      step(dly(a) + 3);
      run_pattern($sformatf("R1 pattern mismatches addr %0d", a), dly(a), 40);
    end
  endtask

  task automatic measure_change(int a, int expk);
    int k = 0;
    bit seen = 0;
    din = 0;
    step(30);
    addr_req = AW'(a);
    while (!seen && k < 200) begin
      @(negedge clk);
      k++;
      if (addr_ready) seen = 1;
    end
    check($sformatf("R5 ready latency %0d->%0d", cur_addr, a), k, expk);
    cur_addr = a;
    step(5);
  endtask

  task automatic test_guard_timing();
    measure_change(2, 2);              // down: no guard
    measure_change(5, (5-2)*STEP + 2); // up by 3
    measure_change(0, 2);
    measure_change(7, 7*STEP + 2);     // full range up
  endtask

  // Pulse in flight between the taps during a move down
  task automatic test_down_inflight();
    int rises = 0;
    int kr = -1;
    logic prev_d;
    din = 0;
    step(30);
    prev_d = dout;
    din = 1;
    @(negedge clk);
    din = 0;
    addr_req = AW'(0);
    for (int c = 0; c < 80; c++) begin
      @(negedge clk);
      if (dout && !prev_d) rises++;
      prev_d = dout;
      if (addr_ready && kr < 0) kr = c + 1;
    end
    check("R6 down move keeps in-flight pulse", rises, 1);
    check("R6 down move held while span busy", int'(kr > 20), 1);
    cur_addr = 0;
    step(5);
  endtask

  // Old history between the taps during a move up
  task automatic test_up_replay();
    int rises = 0;
    bit seen = 0;
    logic prev_d;
    din = 0;
    step(30);
    prev_d = dout;
    din = 1;
    @(negedge clk);
    if (dout && !prev_d) rises++;
    prev_d = dout;
    din = 0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      if (dout && !prev_d) rises++;
      prev_d = dout;
    end
    addr_req = AW'(7);
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (dout && !prev_d) rises++;
      prev_d = dout;
      if (addr_ready) seen = 1;
    end
    check("R6 up move does not replay history", rises, 1);
    check("R6 up move eventually applied", int'(seen), 1);
    cur_addr = 7;
    step(5);
  endtask

  task automatic test_clear();
    int highs;
    din = 0;
    step(30);
    set_addr(3);
    din = 1;
    step(15);
    check("R1 level reaches output before disable", int'(dout), 1);
    en_n = 1;
    @(negedge clk);
    check("R3 output low after disable edge", int'(dout), 0);
    highs = 0;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      if (dout) highs++;
    end
    check("R3 output held low while disabled", highs, 0);
    // early re-enable with no clearing at all
    en_n = 0;
    highs = 0;
    for (int c = 0; c < 10; c++) begin
      din = lf[0];
      lf_next();
      @(negedge clk);
      if (dout) highs++;
    end
    check("R7 early re-enable keeps output low", highs, 0);
    // clearing interval too short (8 of 9 counted edges)
    en_n = 1;
    din = 0;
    step(8);
    en_n = 0;
    din = 1;
    highs = 0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (dout) highs++;
    end
    check("R7 short clearing interval keeps output low", highs, 0);
    // full clearing interval
    en_n = 1;
    din = 0;
    step(14);
    en_n = 0;
    step(3);
    highs = 0;
    for (int c = 0; c < 15; c++) begin
      @(negedge clk);
      if (dout) highs++;
    end
    check("R8 no old history after clear", highs, 0);
    run_pattern("R8 normal delay after re-enable", dly(3), 30);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    test_reset();
    test_all_delays();
    test_guard_timing();
    test_down_inflight();
    test_up_replay();
    test_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule